// File: doc/BRIEF.md
# Hardware Loop and Return Stack

This block is the return and loop stack beside a DSP program sequencer. It keeps a 15-entry store of 64-bit words. A subroutine call or a long interrupt saves a return address and a status word in one entry. A matching return gives them back on registered outputs, together with a one-cycle load pulse that the sequencer uses to redirect fetch.

The block also runs nested zero-overhead DO loops. It owns the loop counter, the loop end address and the loop-active flag. Starting a loop saves the enclosing loop's counter and end address, then saves the loop's first address and the status word. Every cycle while a loop is active, the block compares the incoming PC with the end address.

At each hit, the block either sends fetch back to the start address and counts down, or it retires the loop. Retiring a loop brings back the outer loop's counter, its end address and its active flag. The sequencer applies one push or pop command per cycle. A stack fault is never fatal: it is recorded in a sticky flag, and the stored words stay as they were.

Top module: `hw_loop_stack`

## Requirements
- R1: After reset the stack is empty. `pcOut`, `srOut`, `lcOut` and `laOut` are zero, and `pcLoad`, `srLoad`, `loopFlag`, `busy`, `ovfErr` and `unfErr` are all 0.
- R2: `cmdCall` pushes one entry: bits 63:32 hold `pcIn` (the return address) and bits 31:0 hold `srIn`, with bit 15 of the status replaced by the current `loopFlag`. `cmdRts` pops the top entry. One cycle later `pcLoad` is 1 and `pcOut` equals the stored address, while `srLoad` stays 0.
- R3: `cmdRti` pops the top entry. One cycle later `pcLoad` and `srLoad` are both 1, `pcOut` and `srOut` hold the stored address and status, and `loopFlag` takes bit 15 of the restored status.
- R4: DO is a two-cycle operation.
  - First cycle (`cmdDo`): the block pushes {LA, LC}, loads LC from `doCount` and LA from `doEnd`, and captures `pcIn` as the loop start and `srIn` as the status.
  - Second cycle (`busy`=1): the block pushes {start, status with bit 15 := prior `loopFlag`}, and `loopFlag` becomes 1 after that cycle.
  - Commands presented while `busy` is 1 are ignored.
- R5: `loopHit` is combinational and equals `loopFlag` AND (`pcIn` == `laOut`) AND NOT `busy`.
- R6: On a hit with LC > 1, LC is decremented and nothing is popped. One cycle later `pcLoad` is 1 and `pcOut` is the start address held in the top entry.
- R7: On a hit with LC <= 1, both loop entries are popped in one cycle. LC and LA are restored from the lower entry, `loopFlag` takes bit 15 of the status in the upper entry, and `pcLoad` stays 0.
- R8: When an inner loop of a nested pair retires, `loopFlag` stays 1 and the outer loop's LC and LA are back in place.
- R9: A push onto a full 15-entry stack sets `ovfErr`, which stays set until reset. The entries already stored are returned unchanged by later pops.
- R10: A pop from an empty stack sets `unfErr`, which stays set until reset, and produces no `pcLoad` pulse.
- R11: At most one command takes effect per cycle, in the priority order below. A command in a lower position is dropped, not deferred.
  - A loop hit comes first.
  - Then `cmdCall`.
  - Then `cmdRti`.
  - Then `cmdRts`.
  - Then `cmdDo`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdCall | input | 1 | Push return address and status |
| cmdRts | input | 1 | Pop, restore address only |
| cmdRti | input | 1 | Pop, restore address and status |
| cmdDo | input | 1 | Start a hardware loop |
| pcIn | input | 32 | Current PC (return address on call, loop start on DO) |
| srIn | input | 32 | Current status word |
| doCount | input | 32 | Iteration count for DO |
| doEnd | input | 32 | Last-instruction address for DO |
| pcOut | output | 32 | Restored or loop-start address |
| srOut | output | 32 | Restored status word |
| pcLoad | output | 1 | One-cycle pulse: `pcOut` is valid for fetch |
| srLoad | output | 1 | One-cycle pulse: `srOut` is valid |
| lcOut | output | 32 | Loop counter |
| laOut | output | 32 | Loop end address |
| loopFlag | output | 1 | A loop is active |
| loopHit | output | 1 | PC is at the active loop's end |
| busy | output | 1 | Second cycle of a DO |
| ovfErr | output | 1 | Sticky overflow |
| unfErr | output | 1 | Sticky underflow |

## Verification
The bench goes after four corner cases.

- Nested loops: an inner loop retires while its outer loop is active. If the status bit were not saved with the prior flag, the design would drop `loopFlag` and lose the outer loop.
- Last iteration: a hit with LC equal to 1 must pop both words and produce no reload pulse. An off-by-one test would run one extra pass, or would pop too early.
- Full and empty stack: an extra push at depth 15 and a pop at depth 0. A design that wrote the sixteenth push anyway would return a wrong address on the first pop. A design that popped on empty would raise a spurious `pcLoad`.
- Collisions: a call issued during the busy cycle of a DO, and a call issued in the same cycle as a loop hit, must both vanish. The bench detects a leaked command through a later underflow.

// File: rtl/loopstk_pkg.sv
package loopstk_pkg;

  typedef enum logic [1:0] {
    SRC_CALL      = 2'd0,
    SRC_LOOPREGS  = 2'd1,
    SRC_LOOPSTART = 2'd2
  } pushSrc_e;

  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic     push;
    pushSrc_e pushSrc;
    logic     loadPc;
    logic     loadSr;
    logic     flagFromTop;
    logic     doLoad;
    logic     setFlag;
    logic     clearFlag;
    logic     reload;
    logic     restoreLoop;
  } ctlStrobes_t;

endpackage

// File: rtl/loopstk_ctrl.sv
module loopstk_ctrl
  import loopstk_pkg::*;
#(
  parameter int DEPTH = 15,
  localparam int PW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cmdCall,
  input  logic          cmdRts,
  input  logic          cmdRti,
  input  logic          cmdDo,
  input  logic          atEnd,
  input  logic          lcGtOne,
  input  logic          loopFlag,
  output ctlStrobes_t   stb,
  output logic [PW-1:0] sp,
  output logic          busy,
  output logic          loopHit,
  output logic          ovfErr,
  output logic          unfErr
);

  logic [PW-1:0] spQ, spNext;
  logic phase2Q, phase2D;
  logic ovfQ, unfQ, ovfSet, unfSet;
  logic full, empty, twoAvail;

  assign full     = (spQ == PW'(DEPTH));
  assign empty    = (spQ == '0);
  assign twoAvail = (spQ >= PW'(2));
  assign loopHit  = loopFlag && atEnd && !phase2Q;

  always_comb begin
    stb     = '0;
    spNext  = spQ;
    ovfSet  = 1'b0;
    unfSet  = 1'b0;
    phase2D = 1'b0;
    if (phase2Q) begin
      // second half of DO: start address and status word
      stb.setFlag = 1'b1;
      if (full) begin
        ovfSet = 1'b1;
      end else begin
        stb.push    = 1'b1;
        stb.pushSrc = SRC_LOOPSTART;
        spNext      = spQ + PW'(1);
      end
    end else if (loopHit) begin
      if (lcGtOne) begin
        if (empty) begin
          unfSet        = 1'b1;
          stb.clearFlag = 1'b1;
        end else begin
          stb.reload = 1'b1;
        end
      end else if (twoAvail) begin
        stb.restoreLoop = 1'b1;
        spNext          = spQ - PW'(2);
      end else begin
        unfSet        = 1'b1;
        stb.clearFlag = 1'b1;
      end
    end else if (cmdCall) begin
      if (full) begin
        ovfSet = 1'b1;
      end else begin
        stb.push    = 1'b1;
        stb.pushSrc = SRC_CALL;
        spNext      = spQ + PW'(1);
      end
    end else if (cmdRti) begin
      if (empty) begin
        unfSet = 1'b1;
      end else begin
        stb.loadPc      = 1'b1;
        stb.loadSr      = 1'b1;
        stb.flagFromTop = 1'b1;
        spNext          = spQ - PW'(1);
      end
    end else if (cmdRts) begin
      if (empty) begin
        unfSet = 1'b1;
      end else begin
        stb.loadPc = 1'b1;
        spNext     = spQ - PW'(1);
      end
    end else if (cmdDo) begin
      stb.doLoad = 1'b1;
      phase2D    = 1'b1;
      if (full) begin
        ovfSet = 1'b1;
      end else begin
        stb.push    = 1'b1;
        stb.pushSrc = SRC_LOOPREGS;
        spNext      = spQ + PW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      spQ     <= '0;
      phase2Q <= 1'b0;
      ovfQ    <= 1'b0;
      unfQ    <= 1'b0;
    end else begin
      spQ     <= spNext;
      phase2Q <= phase2D;
      ovfQ    <= ovfQ | ovfSet;
      unfQ    <= unfQ | unfSet;
    end
  end

  assign sp     = spQ;
  assign busy   = phase2Q;
  assign ovfErr = ovfQ;
  assign unfErr = unfQ;

endmodule

// File: rtl/loopstk_dp.sv
module loopstk_dp
  import loopstk_pkg::*;
#(
  parameter int DW       = 32,
  parameter int DEPTH    = 15,
  parameter int FLAG_BIT = 15,
  localparam int PW = $clog2(DEPTH + 1),
  localparam int EW = 2 * DW
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctlStrobes_t   stb,
  input  logic [PW-1:0] sp,
  input  logic [DW-1:0] pcIn,
  input  logic [DW-1:0] srIn,
  input  logic [DW-1:0] doCount,
  input  logic [DW-1:0] doEnd,
  output logic [DW-1:0] pcOut,
  output logic [DW-1:0] srOut,
  output logic          pcLoad,
  output logic          srLoad,
  output logic [DW-1:0] lcOut,
  output logic [DW-1:0] laOut,
  output logic          loopFlag,
  output logic          atEnd,
  output logic          lcGtOne
);

  logic [EW-1:0] mem [DEPTH];
  logic [EW-1:0] pushWord, topWord, nextWord;
  logic [PW-1:0] topIdx, nextIdx;
  logic [DW-1:0] lcQ, laQ, pcOutQ, srOutQ, doStartQ, doSrQ;
  logic          flagQ, pcLoadQ, srLoadQ;

  function automatic logic [DW-1:0] tagFlag(input logic [DW-1:0] s, input logic f);
    logic [DW-1:0] r;
    r = s;
    r[FLAG_BIT] = f;
    return r;
  endfunction

  assign topIdx   = (sp == '0) ? '0 : sp - PW'(1);
  assign nextIdx  = (sp < PW'(2)) ? '0 : sp - PW'(2);
  assign topWord  = mem[topIdx];
  assign nextWord = mem[nextIdx];

  always_comb begin
    case (stb.pushSrc)
      SRC_LOOPREGS:  pushWord = {laQ, lcQ};
      SRC_LOOPSTART: pushWord = {doStartQ, tagFlag(doSrQ, flagQ)};
      default:       pushWord = {pcIn, tagFlag(srIn, flagQ)};
    endcase
  end

  always_ff @(posedge clk) begin
    if (stb.push) mem[sp] <= pushWord;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lcQ      <= '0;
      laQ      <= '0;
      flagQ    <= 1'b0;
      pcOutQ   <= '0;
      srOutQ   <= '0;
      pcLoadQ  <= 1'b0;
      srLoadQ  <= 1'b0;
      doStartQ <= '0;
      doSrQ    <= '0;
    end else begin
      pcLoadQ <= stb.loadPc | stb.reload;
      srLoadQ <= stb.loadSr;
      if (stb.loadPc) pcOutQ <= topWord[EW-1:DW];
      if (stb.loadSr) srOutQ <= topWord[DW-1:0];
      if (stb.flagFromTop) flagQ <= topWord[FLAG_BIT];
      if (stb.reload) begin
        lcQ    <= lcQ - DW'(1);
        pcOutQ <= topWord[EW-1:DW];
      end
      if (stb.restoreLoop) begin
        flagQ <= topWord[FLAG_BIT];
        lcQ   <= nextWord[DW-1:0];
        laQ   <= nextWord[EW-1:DW];
      end
      if (stb.doLoad) begin
        lcQ      <= doCount;
        laQ      <= doEnd;
        doStartQ <= pcIn;
        doSrQ    <= srIn;
      end
      if (stb.setFlag)   flagQ <= 1'b1;
      if (stb.clearFlag) flagQ <= 1'b0;
    end
  end

  assign atEnd    = (pcIn == laQ);
  assign lcGtOne  = (lcQ > DW'(1));
  assign pcOut    = pcOutQ;
  assign srOut    = srOutQ;
  assign pcLoad   = pcLoadQ;
  assign srLoad   = srLoadQ;
  assign lcOut    = lcQ;
  assign laOut    = laQ;
  assign loopFlag = flagQ;

endmodule

// File: rtl/hw_loop_stack.sv
module hw_loop_stack
  import loopstk_pkg::*;
#(
  parameter int DW       = 32,
  parameter int DEPTH    = 15,
  parameter int FLAG_BIT = 15,
  localparam int PW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cmdCall,
  input  logic          cmdRts,
  input  logic          cmdRti,
  input  logic          cmdDo,
  input  logic [DW-1:0] pcIn,
  input  logic [DW-1:0] srIn,
  input  logic [DW-1:0] doCount,
  input  logic [DW-1:0] doEnd,
  output logic [DW-1:0] pcOut,
  output logic [DW-1:0] srOut,
  output logic          pcLoad,
  output logic          srLoad,
  output logic [DW-1:0] lcOut,
  output logic [DW-1:0] laOut,
  output logic          loopFlag,
  output logic          loopHit,
  output logic          busy,
  output logic          ovfErr,
  output logic          unfErr
);

  ctlStrobes_t   stb;
  logic [PW-1:0] sp;
  logic          atEnd, lcGtOne;

  loopstk_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .cmdCall(cmdCall), .cmdRts(cmdRts), .cmdRti(cmdRti), .cmdDo(cmdDo),
    .atEnd(atEnd), .lcGtOne(lcGtOne), .loopFlag(loopFlag),
    .stb(stb), .sp(sp), .busy(busy), .loopHit(loopHit),
    .ovfErr(ovfErr), .unfErr(unfErr)
  );

  loopstk_dp #(.DW(DW), .DEPTH(DEPTH), .FLAG_BIT(FLAG_BIT)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .sp(sp),
    .pcIn(pcIn), .srIn(srIn), .doCount(doCount), .doEnd(doEnd),
    .pcOut(pcOut), .srOut(srOut), .pcLoad(pcLoad), .srLoad(srLoad),
    .lcOut(lcOut), .laOut(laOut), .loopFlag(loopFlag),
    .atEnd(atEnd), .lcGtOne(lcGtOne)
  );

endmodule

// File: rtl/loopstk_chk.sv
module loopstk_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rstN,
  input logic          cmdCall,
  input logic          cmdRts,
  input logic          cmdRti,
  input logic          cmdDo,
  input logic [DW-1:0] lcOut,
  input logic [DW-1:0] laOut,
  input logic          pcLoad,
  input logic          srLoad,
  input logic          loopFlag,
  input logic          loopHit,
  input logic          busy,
  input logic          ovfErr,
  input logic          unfErr
);

  p_no_overflow_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    ovfErr |=> ovfErr);

  p_no_underflow_clear_r10: assert property (@(posedge clk) disable iff (!rstN)
    unfErr |=> unfErr);

  p_busy_single_r4: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> !busy);

  p_flag_after_do_r4: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> loopFlag);

  p_do_enters_busy_r11: assert property (@(posedge clk) disable iff (!rstN)
    (cmdDo && !cmdCall && !cmdRts && !cmdRti && !busy && !loopHit) |=> busy);

  p_hit_gated_r5: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !loopHit);

  p_reload_count_r6: assert property (@(posedge clk) disable iff (!rstN)
    (loopHit && lcOut > DW'(1)) |=> ((pcLoad && lcOut == $past(lcOut) - DW'(1)) || unfErr));

  p_sr_with_pc_r3: assert property (@(posedge clk) disable iff (!rstN)
    srLoad |-> pcLoad);

  p_loop_regs_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !loopHit && !cmdDo) |=> ($stable(lcOut) && $stable(laOut)));

endmodule

bind hw_loop_stack loopstk_chk #(.DW(DW)) u_chk (.*);

// File: tb/tb_hw_loop_stack.sv
`timescale 1ns/100ps
module tb_hw_loop_stack;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdCall = 0, cmdRts = 0, cmdRti = 0, cmdDo = 0;
  logic [31:0] pcIn = 0, srIn = 0, doCount = 0, doEnd = 0;
  logic [31:0] pcOut, srOut, lcOut, laOut;
  logic        pcLoad, srLoad, loopFlag, loopHit, busy, ovfErr, unfErr;

  int nChecks = 0;
  int nFail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  hw_loop_stack dut (
    .clk(clk), .rstN(rstN),
    .cmdCall(cmdCall), .cmdRts(cmdRts), .cmdRti(cmdRti), .cmdDo(cmdDo),
    .pcIn(pcIn), .srIn(srIn), .doCount(doCount), .doEnd(doEnd),
    .pcOut(pcOut), .srOut(srOut), .pcLoad(pcLoad), .srLoad(srLoad),
    .lcOut(lcOut), .laOut(laOut), .loopFlag(loopFlag), .loopHit(loopHit),
    .busy(busy), .ovfErr(ovfErr), .unfErr(unfErr)
  );

  // cmd: 0 idle, 1 call, 2 rts, 3 rti
  typedef struct packed {
    logic [1:0]  cmd;
    logic [31:0] pc;
    logic [31:0] sr;
    logic        expLd;
    logic        expSrLd;
    logic [31:0] expPc;
    logic [31:0] expSr;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{2'd1, 32'h100, 32'h0011,   1'b0, 1'b0, 32'h0,   32'h0},
    '{2'd1, 32'h200, 32'h8022,   1'b0, 1'b0, 32'h0,   32'h0},
    '{2'd1, 32'h300, 32'h0033,   1'b0, 1'b0, 32'h0,   32'h0},
    '{2'd2, 32'h0,   32'h0,      1'b1, 1'b0, 32'h300, 32'h0},
    '{2'd3, 32'h0,   32'h0,      1'b1, 1'b1, 32'h200, 32'h0022},
    '{2'd1, 32'h400, 32'h0044,   1'b0, 1'b0, 32'h0,   32'h0},
    '{2'd3, 32'h0,   32'h0,      1'b1, 1'b1, 32'h400, 32'h0044},
    '{2'd2, 32'h0,   32'h0,      1'b1, 1'b0, 32'h100, 32'h0}
  };

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
  endtask

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic clearCmds();
    cmdCall = 0; cmdRts = 0; cmdRti = 0; cmdDo = 0;
  endtask

  task automatic doReset();
    clearCmds();
    pcIn = 0; srIn = 0; doCount = 0; doEnd = 0;
    rstN = 0;
    cyc(); cyc();
    rstN = 1;
    cyc();
  endtask

  task automatic call(input logic [31:0] pc, input logic [31:0] sr);
    pcIn = pc; srIn = sr; cmdCall = 1;
    cyc();
    clearCmds();
  endtask

  task automatic startDo(input logic [31:0] cnt, input logic [31:0] endA, input logic [31:0] start, input logic [31:0] sr);
    pcIn = start; srIn = sr; doCount = cnt; doEnd = endA; cmdDo = 1;
    cyc();
    clearCmds();
    pcIn = 32'hFFFF_0000;
    cyc();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog expired act=%0d exp=%0d", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    // R1 reset state
    doReset();
    check({pcOut, srOut, lcOut, laOut} == '0 &&
          {pcLoad, srLoad, loopFlag, busy, ovfErr, unfErr} == '0,
          "R1 reset state", {pcOut, lcOut}, 64'h0);

    // R2/R3 vector table: call, rts, rti sequences
    for (int i = 0; i < 8; i++) begin
      vec_t v;
      v = VEC[i];
      pcIn = v.pc; srIn = v.sr;
      cmdCall = (v.cmd == 2'd1);
      cmdRts  = (v.cmd == 2'd2);
      cmdRti  = (v.cmd == 2'd3);
      cyc();
      clearCmds();
      check(pcLoad == v.expLd && srLoad == v.expSrLd &&
            (!v.expLd || pcOut == v.expPc) && (!v.expSrLd || srOut == v.expSr),
            "R2/R3 vector", {pcOut, srOut}, {v.expPc, v.expSr});
    end
    cyc();
    check(pcLoad == 1'b0, "R2 pcLoad single pulse", {63'h0, pcLoad}, 64'h0);

    // R10 underflow on empty stack
    cmdRts = 1; cyc(); clearCmds();
    check(unfErr == 1'b1 && pcLoad == 1'b0, "R10 pop on empty", {62'h0, unfErr, pcLoad}, 64'h2);
    cyc();
    check(unfErr == 1'b1, "R10 underflow sticky", {63'h0, unfErr}, 64'h1);

    // R4 R5 R6 R7 single loop, count 3
    doReset();
    pcIn = 32'h40; srIn = 32'h5; doCount = 3; doEnd = 32'h50; cmdDo = 1;
    cyc();
    clearCmds();
    check(busy == 1'b1 && lcOut == 3 && laOut == 32'h50 && loopFlag == 1'b0,
          "R4 first DO cycle", {lcOut, laOut}, {32'd3, 32'h50});
    cmdCall = 1; pcIn = 32'h999;   // must be ignored while busy
    cyc();
    clearCmds();
    check(busy == 1'b0 && loopFlag == 1'b1, "R4 loop armed", {62'h0, busy, loopFlag}, 64'h1);

    // R3: call inside loop stores flag=1 in bit 15; rti brings it back
    call(32'h77, 32'h1);
    cmdRti = 1; cyc(); clearCmds();
    check(pcLoad && srLoad && pcOut == 32'h77 && srOut == 32'h8001 && loopFlag,
          "R3 rti restores status with loop bit", {pcOut, srOut}, {32'h77, 32'h8001});

    pcIn = 32'h48; #1;
    check(loopHit == 1'b0, "R5 no hit away from end", {63'h0, loopHit}, 64'h0);
    pcIn = 32'h50; #1;
    check(loopHit == 1'b1, "R5 hit at end", {63'h0, loopHit}, 64'h1);
    cyc();
    check(pcLoad && pcOut == 32'h40 && lcOut == 2, "R6 first reload", {pcOut, lcOut}, {32'h40, 32'd2});
    cyc();
    check(pcLoad && pcOut == 32'h40 && lcOut == 1, "R6 second reload", {pcOut, lcOut}, {32'h40, 32'd1});
    cyc();
    check(!pcLoad && lcOut == 0 && laOut == 0 && !loopFlag, "R7 loop retired",
          {lcOut, laOut}, 64'h0);
    pcIn = 32'h0;
    cmdRts = 1; cyc(); clearCmds();
    check(unfErr == 1'b1 && !pcLoad, "R4 call during busy ignored (stack empty)",
          {63'h0, unfErr}, 64'h1);

    // R8 nested loops
    doReset();
    startDo(32'd1, 32'h90, 32'h10, 32'h3);
    startDo(32'd2, 32'h80, 32'h20, 32'h4);
    check(lcOut == 2 && laOut == 32'h80 && loopFlag, "R4 inner loop loaded", {lcOut, laOut}, {32'd2, 32'h80});
    pcIn = 32'h80; cyc();
    check(pcLoad && pcOut == 32'h20 && lcOut == 1, "R6 inner reload", {pcOut, lcOut}, {32'h20, 32'd1});
    cyc();
    check(!pcLoad && loopFlag && lcOut == 1 && laOut == 32'h90, "R8 outer restored, flag kept",
          {lcOut, laOut}, {32'd1, 32'h90});
    pcIn = 32'h90; cyc();
    check(!loopFlag && lcOut == 0 && laOut == 0 && !unfErr, "R7 outer retired",
          {lcOut, laOut}, 64'h0);

    // R9 overflow
    doReset();
    for (int i = 0; i < 15; i++) call(32'h1000 + i, 32'h0);
    check(!ovfErr, "R9 fifteen pushes fit", {63'h0, ovfErr}, 64'h0);
    call(32'hDEAD, 32'h0);
    check(ovfErr, "R9 sixteenth push overflows", {63'h0, ovfErr}, 64'h1);
    for (int i = 14; i >= 0; i--) begin
      cmdRts = 1; cyc(); clearCmds();
      check(pcLoad && pcOut == 32'h1000 + i, "R9 entries intact", {32'h0, pcOut}, {32'h0, 32'h1000 + i});
    end
    check(ovfErr && !unfErr, "R9 overflow sticky", {62'h0, ovfErr, unfErr}, 64'h2);

    // R11 priority
    doReset();
    pcIn = 32'hA0; cmdCall = 1; cmdRts = 1; cyc(); clearCmds();
    check(!pcLoad && !unfErr, "R11 call beats rts", {62'h0, pcLoad, unfErr}, 64'h0);
    pcIn = 32'hB0; cmdCall = 1; cmdRti = 1; cyc(); clearCmds();
    check(!pcLoad, "R11 call beats rti", {63'h0, pcLoad}, 64'h0);
    cmdRts = 1; cyc(); clearCmds();
    check(pcLoad && pcOut == 32'hB0, "R11 second call stored", {32'h0, pcOut}, {32'h0, 32'hB0});
    cmdRts = 1; cyc(); clearCmds();
    check(pcLoad && pcOut == 32'hA0, "R11 first call stored", {32'h0, pcOut}, {32'h0, 32'hA0});
    startDo(32'd2, 32'h30, 32'h28, 32'h0);
    pcIn = 32'h30; cmdCall = 1; cyc(); clearCmds();
    check(pcLoad && pcOut == 32'h28 && lcOut == 1, "R11 hit beats call", {pcOut, lcOut}, {32'h28, 32'd1});
    cyc();
    check(!loopFlag && lcOut == 0, "R11 loop retired", {lcOut, laOut}, 64'h0);
    pcIn = 32'h0;
    cmdRts = 1; cyc(); clearCmds();
    check(unfErr, "R11 dropped call left nothing", {63'h0, unfErr}, 64'h1);

    done = 1;
    summary();
    $finish;
  end

endmodule